// File: doc/BRIEF.md
# Fully Associative Read Cache with Rotating Victim Pointer

This block is a small read-only cache that sits between a requester and a slower lower-level memory. Any 32-byte block may live in any of its 64 entries. There is no index field. Every request compares the upper 27 address bits against all stored tags at once, with one comparator per entry gated by that entry's valid flag. A hit returns the addressed 32-bit word on the following cycle.

On a miss, the cache raises `busy` and asks the lower memory for the block that holds the address. It then takes the eight words of that block in ascending order over a valid/ready channel. The block goes into a victim entry. If any entry is empty, the victim is the lowest-numbered empty entry. If none is empty, the victim is the entry named by a single rotating pointer. The pointer moves to the next entry only when a request hits the entry it names. Fills and hits on other entries leave it in place. This gives a cheap approximation of least-recently-used replacement.

Top module: `fa_cache`

## Requirements
- R1: After reset, every entry is empty, the victim pointer names entry 0, and `busy`, `resp_valid`, `mem_req_valid` and `fill_ready` are all low. The first request after reset therefore misses.
- R2: A request is accepted when `req_valid` is high and `busy` is low. If `req_addr[31:5]` matches the tag of a valid entry, then one cycle later `resp_valid=1`, `resp_hit=1` and `resp_data` holds word `req_addr[4:2]` of that block. Address bits 1:0 are ignored.
- R3: If an accepted request misses, then one cycle later `busy=1` and `mem_req_valid=1`, with `mem_req_addr = {req_addr[31:5], 5'b0}`. Both stay steady until `mem_req_ready` is seen high.
- R4: After the request handshake, `fill_ready` is high and the block arrives as 8 beats (`fill_valid` high), word 0 first, word 7 last. In the cycle after the eighth beat, `resp_valid=1`, `resp_hit=0`, `resp_data` holds the requested word, `busy` is low and the new entry is valid.
- R5: While `busy` is high, `req_valid` is ignored: it produces no response and disturbs no state.
- R6: While any entry is empty, a miss fills the lowest-numbered empty entry instead of the pointer's entry.
- R7: When all entries are valid, a miss replaces the entry the pointer names. The pointer advances by one only when a hit lands on the entry it names. Hits elsewhere and fills do not move it.
- R8: The pointer advances from entry 63 to entry 0.
- R9: Blocks whose addresses differ only in the upper address bits occupy separate entries at the same time; all 64 can be resident together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request strobe |
| req_addr | input | 32 | Byte address of the read |
| busy | output | 1 | Miss in progress; requests are not taken |
| resp_valid | output | 1 | Response strobe, one cycle |
| resp_hit | output | 1 | 1 when the response came from a hit, 0 after a fill |
| resp_data | output | 32 | Requested word |
| mem_req_valid | output | 1 | Block fetch request to lower memory |
| mem_req_addr | output | 32 | Block-aligned fetch address |
| mem_req_ready | input | 1 | Lower memory takes the fetch request |
| fill_valid | input | 1 | A fill word is present |
| fill_data | input | 32 | Fill word, ascending order |
| fill_ready | output | 1 | Cache is taking fill words |

## Verification
The embedded properties rely on the lower memory behaving as follows:
- It raises `mem_req_ready` only while a fetch is pending.
- It sends exactly eight `fill_valid` beats, and only while `fill_ready` is high.

The bench keeps to this. It drives the memory side from the same task that issues the request, answers each fetch exactly once, and sometimes inserts a wait before the ready or an idle gap between fill beats.

Requests are held high throughout every fill, so the rule that requests are ignored while busy is exercised on each miss. The pointer sequences are chosen so that every expected hit or miss follows from the replacement rules alone.

// File: rtl/fa_cache.sv
module fa_cache #(
  parameter int ADDR_W  = 32,
  parameter int WORD_W  = 32,
  parameter int ENTRIES = 64,
  parameter int WORDS   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              busy,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [WORD_W-1:0] resp_data,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_req_ready,
  input  logic              fill_valid,
  input  logic [WORD_W-1:0] fill_data,
  output logic              fill_ready
);
  localparam int BYTE_W = $clog2(WORD_W / 8);
  localparam int WSEL_W = $clog2(WORDS);
  localparam int OFF_W  = BYTE_W + WSEL_W;
  localparam int TAG_W  = ADDR_W - OFF_W;
  localparam int IDX_W  = $clog2(ENTRIES);

  typedef enum logic [1:0] {IDLE, ASK, FILL} state_t;
  state_t state;

  logic [ENTRIES-1:0] valid;
  logic [TAG_W-1:0]   tags  [ENTRIES];
  logic [WORD_W-1:0]  lines [ENTRIES*WORDS];
  logic [IDX_W-1:0]   ptr, victim, hit_idx, free_idx;
  logic [WSEL_W-1:0]  cnt, req_w;
  logic [TAG_W-1:0]   req_tag;
  logic [ENTRIES-1:0] hit_vec;
  logic               accept, any_hit, any_free;
  logic [TAG_W-1:0]   in_tag;
  logic [WSEL_W-1:0]  in_w;
  logic               unused_lsb;

  assign in_tag     = req_addr[ADDR_W-1:OFF_W];
  assign in_w       = req_addr[OFF_W-1:BYTE_W];
  assign unused_lsb = ^req_addr[BYTE_W-1:0];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign hit_vec[e] = valid[e] && (tags[e] == in_tag);
  end

  assign any_hit  = |hit_vec;
  assign any_free = ~&valid;
  assign accept   = req_valid && (state == IDLE);

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx  = IDX_W'(i);
      if (!valid[i])  free_idx = IDX_W'(i);
    end
  end

  assign busy          = (state != IDLE);
  assign mem_req_valid = (state == ASK);
  assign fill_ready    = (state == FILL);
  assign mem_req_addr  = {req_tag, {OFF_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= IDLE;
      valid      <= '0;
      ptr        <= '0;
      victim     <= '0;
      cnt        <= '0;
      req_w      <= '0;
      req_tag    <= '0;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_data  <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (state)
        IDLE: if (accept) begin
          if (any_hit) begin
            resp_valid <= 1'b1;
            resp_hit   <= 1'b1;
            resp_data  <= lines[{hit_idx, in_w}];
            if (hit_idx == ptr) ptr <= ptr + IDX_W'(1);
          end else begin
            req_tag <= in_tag;
            req_w   <= in_w;
            victim  <= any_free ? free_idx : ptr;
            state   <= ASK;
          end
        end
        ASK: if (mem_req_ready) begin
          cnt   <= '0;
          state <= FILL;
        end
        FILL: if (fill_valid) begin
          if (cnt == req_w) resp_data <= fill_data;
          cnt <= cnt + WSEL_W'(1);
          if (cnt == WSEL_W'(WORDS - 1)) begin
            valid[victim] <= 1'b1;
            resp_valid    <= 1'b1;
            resp_hit      <= 1'b0;
            state         <= IDLE;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == FILL && fill_valid) begin
      lines[{victim, cnt}] <= fill_data;
      if (cnt == WSEL_W'(WORDS - 1)) tags[victim] <= req_tag;
    end
  end

  a_r3_miss_asks: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && !any_hit) |=> (busy && mem_req_valid));

  a_r3_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  a_r5_fill_busy: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ready |-> (busy && !mem_req_valid && !resp_valid));

  a_r2_hit_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_hit) |-> $past(req_valid && !busy));

  a_r4_fill_done: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_hit) |-> ($past(fill_valid && fill_ready) && !busy));

  a_r9_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  a_r7_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr != $past(ptr)) |-> ((ptr == $past(ptr) + IDX_W'(1)) && resp_valid && resp_hit));
endmodule

// File: tb/fa_cache_test.sv
module fa_cache_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        busy, resp_valid, resp_hit, mem_req_valid, fill_ready;
  logic [31:0] resp_data, mem_req_addr;
  logic        mem_req_ready = 1'b0;
  logic        fill_valid = 1'b0;
  logic [31:0] fill_data = '0;

  int checks = 0;
  int fails  = 0;

  fa_cache uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .busy(busy), .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_data(resp_data),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_req_ready(mem_req_ready),
    .fill_valid(fill_valid), .fill_data(fill_data), .fill_ready(fill_ready)
  );

  always #(PERIOD / 2) clk = ~clk;

  // {expect_hit, block id, byte offset}; ids 0..63 high-bit blocks, 64..66 extra blocks
  localparam int NV = 15;
  localparam logic [13:0] VEC [NV] = '{
    {1'b0, 8'd64, 5'd4},  {1'b1, 8'd1, 5'd31}, {1'b1, 8'd64, 5'd8},
    {1'b0, 8'd65, 5'd12}, {1'b1, 8'd2, 5'd0},  {1'b1, 8'd65, 5'd28},
    {1'b0, 8'd1, 5'd16},  {1'b0, 8'd2, 5'd20}, {1'b1, 8'd3, 5'd5},
    {1'b1, 8'd64, 5'd24}, {1'b1, 8'd2, 5'd9},  {1'b0, 8'd66, 5'd14},
    {1'b0, 8'd3, 5'd26},  {1'b1, 8'd4, 5'd2},  {1'b0, 8'd66, 5'd30}
  };

  function automatic logic [31:0] blk(input logic [7:0] id);
    case (id)
      8'd64:   blk = 32'h0000_1000;
      8'd65:   blk = 32'h0012_3400;
      8'd66:   blk = 32'hFFFF_FFE0;
      default: blk = {id[5:0], 26'h0};
    endcase
  endfunction

  function automatic logic [31:0] mdata(input logic [31:0] base, input int w);
    mdata = base ^ (32'h1357_9BDF * 32'(w + 1));
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] addr, input logic exp_hit, input string r);
    logic [31:0] base;
    logic        stray;
    base  = {addr[31:5], 5'b0};
    stray = 1'b0;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = addr;
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_hit) begin
      chk(r, {30'b0, resp_valid, resp_hit}, 32'h3);
      chk("R2", resp_data, mdata(base, int'(addr[4:2])));
    end else begin
      chk(r, {30'b0, busy, mem_req_valid}, 32'h3);
      chk("R3", mem_req_addr, base);
      req_valid = 1'b1;
      req_addr  = 32'h0000_1004;
      if (addr[2]) begin
        @(negedge clk);
        chk("R3", {mem_req_valid, mem_req_addr[30:0]}, {1'b1, base[30:0]});
      end
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      for (int w = 0; w < 8; w++) begin
        if (addr[3] && w == 3) begin
          fill_valid = 1'b0;
          @(negedge clk);
          stray |= resp_valid;
        end
        fill_valid = 1'b1;
        fill_data  = mdata(base, w);
        @(negedge clk);
        if (w < 7) stray |= resp_valid;
      end
      fill_valid = 1'b0;
      req_valid  = 1'b0;
      chk("R4", {29'b0, resp_valid, resp_hit, busy}, 32'h4);
      chk("R4", resp_data, mdata(base, int'(addr[4:2])));
      @(negedge clk);
      stray |= resp_valid;
      chk("R5", {31'b0, stray}, 32'h0);
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", {28'b0, busy, resp_valid, mem_req_valid, fill_ready}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {28'b0, busy, resp_valid, mem_req_valid, fill_ready}, 32'h0);

    // fill every entry; the pointer stays at 0, so the lowest empty entry must be used
    for (int i = 0; i < 64; i++) access(blk(8'(i)) + 32'(i % 32), 1'b0, (i == 0) ? "R1" : "R6");
    // every block resident together; hitting in order walks the pointer all the way round
    for (int i = 0; i < 64; i++) access(blk(8'(i)) + 32'((i * 7) % 32), 1'b1, "R9");

    // pointer wrapped to 0: B evicts entry 0, then A0 comes back into entry 0
    access(blk(8'd64), 1'b0, "R8");
    access(blk(8'd0) + 32'd8, 1'b0, "R8");

    for (int v = 0; v < NV; v++)
      access(blk(VEC[v][12:5]) + 32'(VEC[v][4:0]), VEC[v][13], "R7");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule